// File: doc/BRIEF.md
# ISA Clock Divider and I/O Recovery Timer

This block derives the ISA system clock from the PCI clock and enforces the minimum quiet time between two ISA I/O commands that the bridge starts back to back. A single configuration byte holds the clock ratio, which is divide by 4 or divide by 3, and the recovery settings. Each I/O cycle width, 8-bit or 16-bit, has its own enable and its own count of extra ISA clocks. The recovery time is loaded when an I/O command ends. It is counted in PCI clocks, so the 3.5-clock minimum rounds correctly for both ratios.

A cycle sequencer reports the end of each I/O command. It then presents its next request, tagged as a new access or as a byte assembly sub-cycle of the same access. New accesses wait out the full recovery. Sub-cycles wait only for the 3.5-clock minimum. A request that arrives early is held off, not dropped: the grant rises as soon as the timer allows it. Separately, the block times each ISA bus cycle in ISA clocks. It applies the nominal length, the shortening requested by the zero-wait-state input, and the wait states requested by channel-ready.

Top module: `isa_clk_recovery`

## Requirements
- R1: Configuration bit 7 selects the ISA clock ratio: 1 divides the PCI clock by 3 and 0 divides it by 4. `isa_tick` pulses once per ISA period, in the last PCI clock of that period. `sysclk` is high for the first two PCI clocks of each period. A ratio change takes effect at the next period boundary. After reset the ratio is 4.
- R2: The configuration byte resets to 8'h4D. It is loaded from `cfg_wdata` when `cfg_we` is sampled high, holds its value otherwise, and is visible on `cfg_q`.
- R3: With the programmed recovery of the finished width disabled, `io_ready` rises exactly B PCI clock edges after the edge that samples `io_done`. B is 3.5 ISA clocks rounded up: 14 at divide by 4 and 11 at divide by 3.
- R4: For an 8-bit command end (`io_done_16`=0) with bit 6 set, the 3-bit field in bits 5:3 adds that many ISA clocks (N PCI clocks each) to B. Code 000 adds nothing.
- R5: For a 16-bit command end with bit 2 set, the field in bits 1:0 adds 1, 2 or 3 ISA clocks for codes 01, 10 and 11, and 4 ISA clocks for code 00.
- R6: `sub_ready` rises B PCI clock edges after `io_done` regardless of the programmed extra recovery. A request with `req_sub`=1 is granted as soon as `sub_ready` is high.
- R7: `req_grant` is low for a new request (`req_sub`=0) while `io_ready` is low. A request held at `req_valid` is granted in the first clock that `io_ready` is high. `io_ready` stays high until the next `io_done`.
- R8: After `cyc_start`, ticks are counted from the first `isa_tick` edge that follows. With channel-ready high and zero-wait-state low, a 16-bit cycle ends after 3 ISA clocks and an 8-bit cycle after 6. `cyc_done` pulses for one PCI clock after the final tick edge, with `cyc_len` holding the count.
- R9: With zero-wait-state high, a 16-bit memory cycle ends at 2 ISA clocks and any 8-bit cycle at 3. A 16-bit I/O cycle keeps its 3 clocks.
- R10: A tick on which channel-ready is low never ends the cycle, and zero-wait-state is ignored on that tick. The cycle ends on the first later tick with channel-ready high at which the length rules of R8 and R9 allow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration byte write data |
| cfg_q | output | 8 | Current configuration byte |
| sysclk | output | 1 | ISA system clock level |
| isa_tick | output | 1 | Last PCI clock of each ISA period |
| io_done | input | 1 | Pulse: an I/O command has just ended |
| io_done_16 | input | 1 | Width of the ended command, 1 = 16-bit |
| req_valid | input | 1 | Sequencer holds a pending I/O request |
| req_sub | input | 1 | Pending request is a byte assembly sub-cycle |
| req_grant | output | 1 | Pending request may start now |
| io_ready | output | 1 | Full recovery has elapsed |
| sub_ready | output | 1 | Minimum 3.5-clock recovery has elapsed |
| cyc_start | input | 1 | Pulse: an ISA bus cycle begins |
| cyc_16 | input | 1 | Starting cycle is 16-bit |
| cyc_mem | input | 1 | Starting cycle is a memory cycle |
| zws | input | 1 | Zero-wait-state request, active high |
| chrdy | input | 1 | Channel ready, low requests wait states |
| cyc_done | output | 1 | Pulse: the timed cycle has ended |
| cyc_len | output | 6 | Length of the ended cycle in ISA clocks |

## Verification
On every clock, the assertions check that ticks never fall on adjacent PCI clocks and that an ended command always drops `io_ready`. They also check that `sub_ready` is never behind `io_ready`, that ready persists until the next command end, and that the configuration byte holds without a write. For cycle timing, they check that a tick with channel-ready low cannot end a cycle, that no cycle is shorter than 2 clocks, and that a 16-bit I/O cycle is never shortened. The bench scenarios check the exact recovery counts for each ratio and field code, including the code 00 and code 000 corners. They also check the held-off grant timing and the exact cycle lengths under mixed wait and zero-wait patterns.

// File: rtl/isa_rt_pkg.sv
package isa_rt_pkg;

  localparam int unsigned CFG_W     = 8;
  localparam logic [7:0]  CFG_RESET = 8'h4D;

  // field positions within the configuration byte
  localparam int unsigned BIT_DIV3  = 7;
  localparam int unsigned BIT_EN8   = 6;
  localparam int unsigned F8_LSB    = 3;
  localparam int unsigned BIT_EN16  = 2;
  localparam int unsigned F16_LSB   = 0;

  localparam int unsigned SLOW_DIV  = 4;
  localparam int unsigned FAST_DIV  = 3;
  localparam int unsigned MAX_EXTRA = 7;

  function automatic int unsigned div_ratio(input logic div3);
    return div3 ? FAST_DIV : SLOW_DIV;
  endfunction

  // 3.5 ISA clocks as PCI clocks, rounded up: ceil(7*N/2)
  function automatic int unsigned base_pclk(input logic div3);
    int unsigned n;
    n = div_ratio(div3);
    return (7 * n + 1) / 2;
  endfunction

  // programmed extra recovery in ISA clocks for the ended command width
  function automatic int unsigned extra_isa(input logic [7:0] cfg, input logic is16);
    logic [2:0] f8;
    logic [1:0] f16;
    f8  = cfg[F8_LSB +: 3];
    f16 = cfg[F16_LSB +: 2];
    if (is16) begin
      if (!cfg[BIT_EN16]) return 0;
      return (f16 == 2'b00) ? 4 : int'(f16);
    end
    if (!cfg[BIT_EN8]) return 0;
    return int'(f8);
  endfunction

  localparam int unsigned MAX_REC = (7 * SLOW_DIV + 1) / 2 + MAX_EXTRA * SLOW_DIV;

  function automatic int unsigned nominal_len(input logic is16);
    return is16 ? 3 : 6;
  endfunction

  function automatic int unsigned short_len(input logic is16, input logic mem);
    if (is16) return mem ? 2 : 3;
    return 3;
  endfunction

endpackage

// File: rtl/isa_clk_div.sv
module isa_clk_div #(
  parameter int unsigned PH_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_div3,
  output logic isa_tick,
  output logic sysclk,
  output logic div3_act
);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] last_ph;
  logic            div3_q;

  assign last_ph  = div3_q ? PH_W'(isa_rt_pkg::FAST_DIV - 1) : PH_W'(isa_rt_pkg::SLOW_DIV - 1);
  assign isa_tick = (phase_q == last_ph);
  assign sysclk   = (phase_q < PH_W'(2));
  assign div3_act = div3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      div3_q  <= 1'b0;
    end else if (isa_tick) begin
      phase_q <= '0;
      div3_q  <= sel_div3;
    end else begin
      phase_q <= phase_q + PH_W'(1);
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    isa_tick |=> !isa_tick); // R1

endmodule

// File: rtl/io_recovery.sv
module io_recovery #(
  parameter int unsigned CNT_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       div3_act,
  input  logic [7:0] cfg,
  input  logic       io_done,
  input  logic       io_done_16,
  input  logic       req_valid,
  input  logic       req_sub,
  output logic       io_ready,
  output logic       sub_ready,
  output logic       req_grant
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] xtra_q;
  logic [CNT_W-1:0] base_c;
  logic [CNT_W-1:0] xtra_c;
  logic [CNT_W-1:0] load_c;

  always_comb begin
    base_c = CNT_W'(isa_rt_pkg::base_pclk(div3_act));
    xtra_c = CNT_W'(isa_rt_pkg::extra_isa(cfg, io_done_16) * isa_rt_pkg::div_ratio(div3_act));
    load_c = base_c + xtra_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      xtra_q <= '0;
    end else if (io_done) begin
      cnt_q  <= load_c;
      xtra_q <= xtra_c;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assign io_ready  = (cnt_q == '0);
  assign sub_ready = (cnt_q <= xtra_q);
  assign req_grant = req_valid & (req_sub ? sub_ready : io_ready);

  AST_DONE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    io_done |=> !io_ready); // R3
  AST_SUB_NOT_BEHIND: assert property (@(posedge clk) disable iff (!rst_n)
    io_ready |-> sub_ready); // R6
  AST_READY_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    io_ready && !io_done |=> io_ready); // R7

endmodule

// File: rtl/isa_cyc_len.sv
module isa_cyc_len #(
  parameter int unsigned LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             isa_tick,
  input  logic             cyc_start,
  input  logic             cyc_16,
  input  logic             cyc_mem,
  input  logic             zws,
  input  logic             chrdy,
  output logic             cyc_done,
  output logic [LEN_W-1:0] cyc_len
);

  logic             busy_q;
  logic             is16_q;
  logic             mem_q;
  logic [LEN_W-1:0] k_q;
  logic [LEN_W-1:0] k_next;
  logic [LEN_W-1:0] nom_c;
  logic [LEN_W-1:0] shr_c;
  logic             can_short;
  logic             finish;
  logic             done_q;
  logic [LEN_W-1:0] len_q;

  always_comb begin
    nom_c     = LEN_W'(isa_rt_pkg::nominal_len(is16_q));
    shr_c     = LEN_W'(isa_rt_pkg::short_len(is16_q, mem_q));
    can_short = (shr_c < nom_c);
    k_next    = (k_q == '1) ? k_q : k_q + LEN_W'(1);
    finish    = busy_q & isa_tick & chrdy &
                ((zws & can_short & (k_next >= shr_c)) | (k_next >= nom_c));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      is16_q <= 1'b0;
      mem_q  <= 1'b0;
      k_q    <= '0;
      done_q <= 1'b0;
      len_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (cyc_start && !busy_q) begin
        busy_q <= 1'b1;
        is16_q <= cyc_16;
        mem_q  <= cyc_mem;
        k_q    <= '0;
      end else if (busy_q && isa_tick) begin
        if (finish) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          len_q  <= k_next;
        end else begin
          k_q <= k_next;
        end
      end
    end
  end

  assign cyc_done = done_q;
  assign cyc_len  = len_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !cyc_done); // R8
  AST_NO_SHORTER_THAN_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> cyc_len >= LEN_W'(2)); // R9
  AST_IO16_NOT_SHORTENED: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done && is16_q && !mem_q |-> cyc_len >= LEN_W'(3)); // R9
  AST_WAIT_WHEN_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && isa_tick && !chrdy |=> !cyc_done); // R10

endmodule

// File: rtl/isa_clk_recovery.sv
module isa_clk_recovery #(
  parameter int unsigned LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_q,
  output logic             sysclk,
  output logic             isa_tick,
  input  logic             io_done,
  input  logic             io_done_16,
  input  logic             req_valid,
  input  logic             req_sub,
  output logic             req_grant,
  output logic             io_ready,
  output logic             sub_ready,
  input  logic             cyc_start,
  input  logic             cyc_16,
  input  logic             cyc_mem,
  input  logic             zws,
  input  logic             chrdy,
  output logic             cyc_done,
  output logic [LEN_W-1:0] cyc_len
);

  localparam int unsigned REC_W = $clog2(isa_rt_pkg::MAX_REC + 1);
  localparam int unsigned PH_W  = $clog2(isa_rt_pkg::SLOW_DIV);

  logic [7:0] cfg_r;
  logic       div3_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_r <= isa_rt_pkg::CFG_RESET;
    else if (cfg_we) cfg_r <= cfg_wdata;
  end

  assign cfg_q = cfg_r;

  isa_clk_div #(.PH_W(PH_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_div3 (cfg_r[isa_rt_pkg::BIT_DIV3]),
    .isa_tick (isa_tick),
    .sysclk   (sysclk),
    .div3_act (div3_act)
  );

  io_recovery #(.CNT_W(REC_W)) u_rec (
    .clk        (clk),
    .rst_n      (rst_n),
    .div3_act   (div3_act),
    .cfg        (cfg_r),
    .io_done    (io_done),
    .io_done_16 (io_done_16),
    .req_valid  (req_valid),
    .req_sub    (req_sub),
    .io_ready   (io_ready),
    .sub_ready  (sub_ready),
    .req_grant  (req_grant)
  );

  isa_cyc_len #(.LEN_W(LEN_W)) u_len (
    .clk       (clk),
    .rst_n     (rst_n),
    .isa_tick  (isa_tick),
    .cyc_start (cyc_start),
    .cyc_16    (cyc_16),
    .cyc_mem   (cyc_mem),
    .zws       (zws),
    .chrdy     (chrdy),
    .cyc_done  (cyc_done),
    .cyc_len   (cyc_len)
  );

  AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_q)); // R2

endmodule

// File: tb/sim_isa_clk_recovery.sv
module sim_isa_clk_recovery;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_q;
  logic       sysclk, isa_tick;
  logic       io_done = 1'b0, io_done_16 = 1'b0;
  logic       req_valid = 1'b0, req_sub = 1'b0;
  logic       req_grant, io_ready, sub_ready;
  logic       cyc_start = 1'b0, cyc_16 = 1'b0, cyc_mem = 1'b0;
  logic       zws = 1'b0, chrdy = 1'b1;
  logic       cyc_done;
  logic [5:0] cyc_len;

  int n_tests = 0;
  int n_fail  = 0;
  bit fin     = 1'b0;

  always #10 clk = ~clk;

  isa_clk_recovery u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .sysclk(sysclk), .isa_tick(isa_tick), .io_done(io_done), .io_done_16(io_done_16),
    .req_valid(req_valid), .req_sub(req_sub), .req_grant(req_grant),
    .io_ready(io_ready), .sub_ready(sub_ready), .cyc_start(cyc_start),
    .cyc_16(cyc_16), .cyc_mem(cyc_mem), .zws(zws), .chrdy(chrdy),
    .cyc_done(cyc_done), .cyc_len(cyc_len)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected model, written from the requirements
  function automatic int ratio_of(input bit d3);
    return d3 ? 3 : 4;
  endfunction
  function automatic int exp_base(input bit d3);
    int n;
    n = ratio_of(d3);
    return (7 * n) / 2 + ((7 * n) % 2);
  endfunction
  function automatic int exp_extra(input logic [7:0] c, input bit w16);
    if (w16) begin
      if (c[2] == 1'b0) return 0;
      case (c[1:0])
        2'b00:   return 4;
        2'b01:   return 1;
        2'b10:   return 2;
        default: return 3;
      endcase
    end
    if (c[6] == 1'b0) return 0;
    return int'(c[5:3]);
  endfunction
  function automatic int exp_cyc(input bit w16, input bit mem, input bit z, input int wt);
    int nom, sh;
    nom = w16 ? 3 : 6;
    sh  = (w16 && !mem) ? 3 : (w16 ? 2 : 3);
    for (int k = 1; k < 40; k++) begin
      if (k > wt && ((z && sh < nom && k >= sh) || k >= nom)) return k;
    end
    return -1;
  endfunction

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic tick_period(output int per, output int hi);
    int g;
    g = 0;
    while (!isa_tick && g < 20) begin @(negedge clk); g++; end
    @(negedge clk);
    per = 1; hi = sysclk ? 1 : 0;
    while (!isa_tick && per < 20) begin
      @(negedge clk); per++;
      if (sysclk) hi++;
    end
  endtask

  task automatic meas(input bit w16, input bit rv, input bit rs,
                      output int t_new, output int t_sub, output int g_first, output int g_ready);
    @(negedge clk);
    io_done = 1'b1; io_done_16 = w16; req_valid = rv; req_sub = rs;
    @(posedge clk);
    @(negedge clk);
    io_done = 1'b0;
    t_new = 0; t_sub = -1; g_first = int'(req_grant); g_ready = 0;
    while (!io_ready && t_new < 200) begin
      if (sub_ready && t_sub < 0) t_sub = t_new;
      @(posedge clk); @(negedge clk);
      t_new++;
      if (rs && sub_ready && t_sub < 0) g_ready = int'(req_grant);
    end
    if (t_sub < 0) t_sub = t_new;
    if (!rs) g_ready = int'(req_grant);
    req_valid = 1'b0; req_sub = 1'b0;
  endtask

  task automatic run_cyc(input bit w16, input bit mem, input bit z, input int wt, input string tag);
    int e, k, g;
    bit ended;
    e = exp_cyc(w16, mem, z, wt);
    @(negedge clk);
    cyc_start = 1'b1; cyc_16 = w16; cyc_mem = mem;
    @(posedge clk);
    @(negedge clk);
    cyc_start = 1'b0;
    k = 0; ended = 1'b0;
    while (!ended && k < 30) begin
      g = 0;
      while (!isa_tick && g < 10) begin @(negedge clk); g++; end
      k++;
      chrdy = (k > wt);
      zws   = z;
      @(posedge clk);
      @(negedge clk);
      if (cyc_done || k == e) begin
        chk({tag, " done flag"}, int'(cyc_done), 1);
        chk({tag, " length"}, k, e);
        chk({tag, " cyc_len"}, int'(cyc_len), e);
        ended = 1'b1;
      end
    end
    chrdy = 1'b1; zws = 1'b0;
    @(negedge clk);
    chk({tag, " done one pulse"}, int'(cyc_done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int per, hi, tn, ts, gf, gr;
    logic [7:0] c;
    bit w;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset value of the configuration byte
    chk("R2 reset cfg", int'(cfg_q), 8'h4D);
    // R1 default ratio after reset is 4
    tick_period(per, hi);
    chk("R1 reset tick period", per, 4);
    chk("R1 sysclk high phases div4", hi, 2);

    // R4 reset setting: 8-bit enabled, code 001 -> 14 + 4
    meas(1'b0, 1'b0, 1'b0, tn, ts, gf, gr);
    chk("R4 default 8-bit recovery", tn, 18);
    chk("R6 default 8-bit sub recovery", ts, 14);
    // R5 reset setting: 16-bit enabled, code 01 -> 14 + 4
    meas(1'b1, 1'b0, 1'b0, tn, ts, gf, gr);
    chk("R5 default 16-bit recovery", tn, 18);

    // R3 both programmed recoveries disabled, divide by 4
    write_cfg(8'b0_0_111_0_11);
    chk("R2 cfg written", int'(cfg_q), 8'h3B);
    meas(1'b0, 1'b0, 1'b0, tn, ts, gf, gr);
    chk("R3 base 8-bit div4", tn, 14);
    meas(1'b1, 1'b0, 1'b0, tn, ts, gf, gr);
    chk("R3 base 16-bit div4", tn, 14);

    // R1 divide by 3, R3 base at divide by 3
    write_cfg(8'b1_0_000_0_00);
    tick_period(per, hi);
    chk("R1 div3 tick period", per, 3);
    chk("R1 sysclk high phases div3", hi, 2);
    meas(1'b0, 1'b0, 1'b0, tn, ts, gf, gr);
    chk("R3 base div3", tn, 11);

    // R5 code 00 means 4 extra clocks
    write_cfg(8'b0_0_000_1_00);
    meas(1'b1, 1'b0, 1'b0, tn, ts, gf, gr);
    chk("R5 code00 div4", tn, 30);
    chk("R6 sub ignores 16-bit extra", ts, 14);

    // R4 code 000 adds nothing; code 111 at divide by 3
    write_cfg(8'b0_1_000_0_00);
    meas(1'b0, 1'b0, 1'b0, tn, ts, gf, gr);
    chk("R4 code000", tn, 14);
    write_cfg(8'b1_1_111_0_00);
    meas(1'b0, 1'b0, 1'b0, tn, ts, gf, gr);
    chk("R4 code111 div3", tn, 32);
    chk("R6 sub base div3", ts, 11);

    // R7 new request held off then granted; R6 sub request granted early
    write_cfg(8'h4D);
    meas(1'b0, 1'b1, 1'b0, tn, ts, gf, gr);
    chk("R7 grant low while recovering", gf, 0);
    chk("R7 grant at ready", gr, 1);
    chk("R7 ready time", tn, 18);
    meas(1'b0, 1'b1, 1'b1, tn, ts, gf, gr);
    chk("R6 sub grant low at start", gf, 0);
    chk("R6 sub grant at base", gr, 1);

    // random recovery settings
    for (int i = 0; i < 24; i++) begin
      c = 8'($urandom);
      w = 1'($urandom);
      write_cfg(c);
      meas(w, 1'b0, 1'b0, tn, ts, gf, gr);
      chk(w ? "R5 random recovery" : "R4 random recovery",
          tn, exp_base(c[7]) + exp_extra(c, w) * ratio_of(c[7]));
      chk("R6 random sub recovery", ts, exp_base(c[7]));
    end

    // cycle length, directed
    write_cfg(8'h4D);
    run_cyc(1'b1, 1'b1, 1'b0, 0, "R8 16-bit nominal");
    run_cyc(1'b0, 1'b0, 1'b0, 0, "R8 8-bit nominal");
    run_cyc(1'b1, 1'b1, 1'b1, 0, "R9 16-bit mem zws");
    run_cyc(1'b1, 1'b0, 1'b1, 0, "R9 16-bit io zws");
    run_cyc(1'b0, 1'b1, 1'b1, 0, "R9 8-bit mem zws");
    run_cyc(1'b1, 1'b1, 1'b1, 2, "R10 zws with not ready");
    run_cyc(1'b0, 1'b0, 1'b0, 8, "R10 long wait");
    write_cfg(8'hCD);
    run_cyc(1'b0, 1'b0, 1'b1, 1, "R10 div3 wait then zws");

    // cycle length, random
    for (int i = 0; i < 24; i++) begin
      run_cyc(1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 5), "R10 random cycle");
    end

    fin = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule